// File: doc/BRIEF.md
# Counted PIO Burst FIFO Bridge

This block joins a slow 16-bit host port to an internal packet data path. Before a burst the host writes the number of 16-bit words it will move into a receive-count or transmit-count control register. On a receive burst the bridge fetches words from the receive packet FIFO ahead of the host into an 8-word buffer. On a transmit burst it posts host writes into the same buffer and drains them to the transmit packet FIFO. Either way, the internal latency stays hidden behind a host wait signal that is raised only when the buffer cannot serve the access.

The upper five bits of the receive-count register choose a register window. Its decoded class and table index go out to the rest of the card. While a burst is in flight, the host may touch only the data port, the two count registers and the status register. Any other access is refused and flagged. A configuration input lets memory-space accesses in the upper half of a 4 KiB range reach the data port as well.

Top module: `pio_burst_bridge`

## Requirements
- R1: Each count register holds an 11-bit word count in bits 10:0, loaded by a host write. The receive count drops by one per word taken from the receive FIFO, and the transmit count drops by one per word handed to the transmit FIFO. A read at offset 0x002 returns {window, receive count}, and a read at offset 0x004 returns the transmit count.
- R2: During a receive burst the bridge fetches at most 8 words ahead of the host and never more words than the loaded count.
- R3: A data-port read (offset 0x000) waits only while the buffer is empty and the receive count is nonzero. With words buffered it completes without wait and returns them in arrival order.
- R4: During a transmit burst a data-port write waits only while all 8 buffer entries are full. The buffer drains one word per cycle whenever the transmit FIFO is ready, preserving order.
- R5: A data-port write beyond the loaded transmit count is dropped and flags host_err. A data-port read with no word buffered and a zero receive count returns 0 and flags host_err.
- R6: While busy, an access to any other address (a window register access) is not forwarded (reg_req stays 0) and flags host_err. When idle, such an access is forwarded with reg_req=1.
- R7: Any write to either count register first cancels the transfer in progress: it empties the buffer and clears both counts. Writing zero therefore leaves the bridge idle, and no further words are fetched.
- R8: Window bits 15:11 of the receive-count register decode as follows. Value 0 gives class 0 (normal). Values 1 to 5 give class 1 (card control). Values 6 to 15 give class 2 (reserved). Values 16 to 31 give class 3 (table) with table index 31 minus the window.
- R9: With cfg_mem_route=1, a memory-space access with address bit 11 set reaches the data port. With cfg_mem_route=0 the same access is treated as a window register access.
- R10: The status register (offset 0x006) returns 1 in bit 0 while either count is nonzero or the buffer holds a word, and 0 otherwise.
- R11: After reset both counts, the window and the status read 0, and host_wait is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mem_route | input | 1 | Route upper memory-space range to the data port |
| host_req | input | 1 | Host access request, held until host_wait is low |
| host_mem | input | 1 | 1 = memory-space access, 0 = I/O access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid in the cycle the access completes |
| host_wait | output | 1 | Stall: access cannot complete this cycle |
| host_err | output | 1 | Completing access was refused or had nothing to move |
| rxf_valid | input | 1 | Receive FIFO has a word |
| rxf_data | input | 16 | Receive FIFO head word |
| rxf_pop | output | 1 | Take the receive FIFO head word |
| txf_ready | input | 1 | Transmit FIFO can accept a word |
| txf_data | output | 16 | Word to the transmit FIFO |
| txf_push | output | 1 | Transmit FIFO write strobe |
| reg_req | output | 1 | Forwarded window register access |
| reg_we | output | 1 | Forwarded access is a write |
| reg_addr | output | 12 | Forwarded address |
| reg_wdata | output | 16 | Forwarded write data |
| reg_rdata | input | 16 | Read data of forwarded access |
| win_sel | output | 5 | Selected window number |
| win_kind | output | 2 | Window class (0 normal, 1 card, 2 reserved, 3 table) |
| win_tbl_idx | output | 4 | Table index for table windows, else 0 |

## Verification
A count register left wrong shows at once in the count read-back and in the busy bit. Within a few cycles it also shows as extra or missing pops on the receive FIFO, or as an early or late error on the data port. A broken buffer pointer or level shows as words out of order or duplicated at the host or the transmit FIFO. It can also show as a wait that appears with words buffered, or as fetching that runs past 8 words within 8 cycles of the burst start. A cancel that fails to empty the buffer leaves the status bit set and the data port returning stale words on the very next access.

// File: rtl/pio_bridge_pkg.sv
package pio_bridge_pkg;
   typedef enum logic [1:0] {DIR_IDLE = 2'd0, DIR_RX = 2'd1, DIR_TX = 2'd2} dir_e;
   typedef enum logic [1:0] {WK_NORMAL = 2'd0, WK_CARD = 2'd1,
                             WK_RSVD = 2'd2, WK_TABLE = 2'd3} win_kind_e;
   typedef enum logic [2:0] {AC_DATA = 3'd0, AC_RDCTL = 3'd1, AC_WRCTL = 3'd2,
                             AC_STAT = 3'd3, AC_WIN = 3'd4} acc_e;
   localparam logic [11:0] OFS_DATA  = 12'h000;
   localparam logic [11:0] OFS_RDCTL = 12'h002;
   localparam logic [11:0] OFS_WRCTL = 12'h004;
   localparam logic [11:0] OFS_STAT  = 12'h006;
   localparam int          CARD_LAST = 5;
endpackage

// File: rtl/pb_down_counter.sv
module pb_down_counter #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         nz
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (load)            cnt <= load_val;
      else if (dec && cnt != 0) cnt <= cnt - 1'b1;
   end
   assign nz = (cnt != '0);
endmodule

// File: rtl/pb_word_buf.sv
module pb_word_buf #(
   parameter int DW    = 16,
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     push,
   input  logic [DW-1:0]            din,
   input  logic                     pop,
   output logic [DW-1:0]            dout,
   output logic                     empty,
   output logic                     full,
   output logic [$clog2(DEPTH):0]   level
);
   localparam int PW = $clog2(DEPTH);
   logic [PW-1:0] wptr, rptr;
   logic [DW-1:0] rd_vec [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= '0;
         else if (push && !flush && wptr == PW'(g)) q <= din;
      end
      assign rd_vec[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         level <= level + (PW+1)'(push) - (PW+1)'(pop);
      end
   end

   assign dout  = rd_vec[rptr];
   assign empty = (level == '0);
   assign full  = (level == (PW+1)'(DEPTH));
endmodule

// File: rtl/pb_addr_decode.sv
module pb_addr_decode
   import pio_bridge_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic          host_mem,
   input  logic [AW-1:0] addr,
   input  logic          route_en,
   output acc_e          acc
);
   always_comb begin
      acc = AC_WIN;
      if (host_mem) begin
         if (route_en && addr[AW-1]) acc = AC_DATA;
      end else begin
         if      (addr == AW'(OFS_DATA))  acc = AC_DATA;
         else if (addr == AW'(OFS_RDCTL)) acc = AC_RDCTL;
         else if (addr == AW'(OFS_WRCTL)) acc = AC_WRCTL;
         else if (addr == AW'(OFS_STAT))  acc = AC_STAT;
      end
   end
endmodule

// File: rtl/pb_win_decode.sv
module pb_win_decode
   import pio_bridge_pkg::*;
#(
   parameter int WIN_W = 5
) (
   input  logic [WIN_W-1:0] win,
   output win_kind_e        kind,
   output logic [WIN_W-2:0] tbl_idx
);
   always_comb begin
      tbl_idx = '0;
      if (win[WIN_W-1]) begin
         kind    = WK_TABLE;
         tbl_idx = ~win[WIN_W-2:0];
      end else if (win == '0)
         kind = WK_NORMAL;
      else if (win <= WIN_W'(CARD_LAST))
         kind = WK_CARD;
      else
         kind = WK_RSVD;
   end
endmodule

// File: rtl/pio_burst_bridge.sv
module pio_burst_bridge
   import pio_bridge_pkg::*;
#(
   parameter int DW    = 16,
   parameter int AW    = 12,
   parameter int CNT_W = 11,
   parameter int WIN_W = 5,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_mem_route,
   input  logic             host_req,
   input  logic             host_mem,
   input  logic             host_we,
   input  logic [AW-1:0]    host_addr,
   input  logic [DW-1:0]    host_wdata,
   output logic [DW-1:0]    host_rdata,
   output logic             host_wait,
   output logic             host_err,
   input  logic             rxf_valid,
   input  logic [DW-1:0]    rxf_data,
   output logic             rxf_pop,
   input  logic             txf_ready,
   output logic [DW-1:0]    txf_data,
   output logic             txf_push,
   output logic             reg_req,
   output logic             reg_we,
   output logic [AW-1:0]    reg_addr,
   output logic [DW-1:0]    reg_wdata,
   input  logic [DW-1:0]    reg_rdata,
   output logic [WIN_W-1:0] win_sel,
   output logic [1:0]       win_kind,
   output logic [WIN_W-2:0] win_tbl_idx
);
   localparam int LVL_W = $clog2(DEPTH) + 1;

   if (CNT_W + WIN_W != DW) begin : g_chk_split
      $error("count and window fields must fill the data word");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("buffer depth must be a power of two, at least 2");
   end
   if (CNT_W < LVL_W || AW < 12) begin : g_chk_widths
      $error("count or address width too small");
   end

   acc_e            acc;
   dir_e            dir;
   logic [CNT_W-1:0] rd_cnt, wr_cnt;
   logic            rd_nz, wr_nz;
   logic [DW-1:0]   buf_dout;
   logic            buf_empty, buf_full;
   logic [LVL_W-1:0] buf_level;
   logic            busy, data_rd, data_wr, go, ctl_wr;
   logic            host_pop, wr_accept, buf_push, buf_pop;
   logic [CNT_W-1:0] rd_load, wr_load;
   win_kind_e       kind;

   pb_addr_decode #(.AW(AW)) u_dec (
      .host_mem(host_mem), .addr(host_addr), .route_en(cfg_mem_route), .acc(acc));

   assign busy    = rd_nz | wr_nz | ~buf_empty;
   assign data_rd = host_req && acc == AC_DATA && !host_we;
   assign data_wr = host_req && acc == AC_DATA && host_we;

   assign host_wait = (data_rd && dir == DIR_RX && buf_empty && rd_nz) ||
                      (data_wr && dir == DIR_TX && buf_full);
   assign go        = host_req && !host_wait;
   assign ctl_wr    = go && host_we && (acc == AC_RDCTL || acc == AC_WRCTL);

   assign host_pop  = go && data_rd && dir == DIR_RX && !buf_empty;
   assign wr_accept = go && data_wr && dir == DIR_TX &&
                      (wr_cnt > {{(CNT_W-LVL_W){1'b0}}, buf_level});

   assign rxf_pop  = dir == DIR_RX && rd_nz && !buf_full && rxf_valid && !ctl_wr;
   assign txf_push = dir == DIR_TX && !buf_empty && txf_ready && !ctl_wr;
   assign txf_data = buf_dout;

   assign buf_push = rxf_pop | wr_accept;
   assign buf_pop  = host_pop | txf_push;

   pb_word_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(ctl_wr), .push(buf_push),
      .din(dir == DIR_RX ? rxf_data : host_wdata), .pop(buf_pop),
      .dout(buf_dout), .empty(buf_empty), .full(buf_full), .level(buf_level));

   assign rd_load = (acc == AC_RDCTL) ? host_wdata[CNT_W-1:0] : '0;
   assign wr_load = (acc == AC_WRCTL) ? host_wdata[CNT_W-1:0] : '0;

   pb_down_counter #(.W(CNT_W)) u_rd_cnt (
      .clk(clk), .rst_n(rst_n), .load(ctl_wr), .load_val(rd_load),
      .dec(rxf_pop), .cnt(rd_cnt), .nz(rd_nz));

   pb_down_counter #(.W(CNT_W)) u_wr_cnt (
      .clk(clk), .rst_n(rst_n), .load(ctl_wr), .load_val(wr_load),
      .dec(txf_push), .cnt(wr_cnt), .nz(wr_nz));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir     <= DIR_IDLE;
         win_sel <= '0;
      end else if (ctl_wr) begin
         if (acc == AC_RDCTL) begin
            win_sel <= host_wdata[DW-1 -: WIN_W];
            dir     <= (rd_load != '0) ? DIR_RX : DIR_IDLE;
         end else begin
            dir     <= (wr_load != '0) ? DIR_TX : DIR_IDLE;
         end
      end
   end

   pb_win_decode #(.WIN_W(WIN_W)) u_win (
      .win(win_sel), .kind(kind), .tbl_idx(win_tbl_idx));
   assign win_kind = kind;

   assign reg_req   = go && acc == AC_WIN && !busy;
   assign reg_we    = host_we;
   assign reg_addr  = host_addr;
   assign reg_wdata = host_wdata;

   assign host_err = go && ((acc == AC_WIN && busy) ||
                            (data_rd && !host_pop) ||
                            (data_wr && !wr_accept));

   always_comb begin
      host_rdata = '0;
      if (go && !host_we) begin
         case (acc)
            AC_DATA:  host_rdata = host_pop ? buf_dout : '0;
            AC_RDCTL: host_rdata = {win_sel, rd_cnt};
            AC_WRCTL: host_rdata = {{WIN_W{1'b0}}, wr_cnt};
            AC_STAT:  host_rdata = {{(DW-1){1'b0}}, busy};
            default:  host_rdata = reg_req ? reg_rdata : '0;
         endcase
      end
   end
endmodule

// File: rtl/pio_burst_bridge_chk.sv
module pio_burst_bridge_chk #(
   parameter int CNT_W = 11,
   parameter int DEPTH = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   rxf_pop,
   input logic                   rxf_valid,
   input logic                   txf_push,
   input logic                   txf_ready,
   input logic                   reg_req,
   input logic                   host_err,
   input logic                   host_wait,
   input logic                   busy,
   input logic                   ctl_wr,
   input logic [CNT_W-1:0]       rd_cnt,
   input logic [$clog2(DEPTH):0] buf_level
);
   p_pop_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_pop |-> rxf_valid);
   p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      buf_level <= ($clog2(DEPTH)+1)'(DEPTH));
   p_one_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rxf_pop && txf_push));
   p_tx_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      txf_push |-> txf_ready);
   p_fwd_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req |-> !host_err && !busy);
   p_wait_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      host_wait |-> busy && !host_err);
   p_rd_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_pop && !ctl_wr) |=> rd_cnt == CNT_W'($past(rd_cnt) - 1'b1));
   p_cancel_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> buf_level == '0);
endmodule

bind pio_burst_bridge pio_burst_bridge_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .rxf_pop(rxf_pop), .rxf_valid(rxf_valid),
   .txf_push(txf_push), .txf_ready(txf_ready), .reg_req(reg_req),
   .host_err(host_err), .host_wait(host_wait), .busy(busy), .ctl_wr(ctl_wr),
   .rd_cnt(rd_cnt), .buf_level(buf_level));

// File: tb/pio_burst_bridge_tb.sv
`timescale 1ns/1ps
module pio_burst_bridge_tb;
   logic clk = 0, rst_n = 0, cfg_mem_route = 0;
   logic host_req = 0, host_mem = 0, host_we = 0;
   logic [11:0] host_addr = 0;
   logic [15:0] host_wdata = 0, host_rdata;
   logic host_wait, host_err;
   logic rxf_valid = 0, rxf_pop;
   logic [15:0] rxf_data = 0, txf_data, reg_rdata = 16'h5A5A, reg_wdata;
   logic txf_ready = 0, txf_push, reg_req, reg_we;
   logic [11:0] reg_addr;
   logic [4:0] win_sel;
   logic [1:0] win_kind;
   logic [3:0] win_tbl_idx;

   int total = 0, bad = 0, pops = 0;
   bit rx_en = 0;
   logic [15:0] rxq[$];
   logic [15:0] txq[$];

   always #2.5 clk = ~clk;

   pio_burst_bridge u_dut (.*);

   always @(negedge clk) begin
      rxf_valid = rx_en && rxq.size() != 0;
      rxf_data  = (rxq.size() != 0) ? rxq[0] : 16'h0;
   end
   always @(posedge clk) begin
      if (rxf_pop && rxq.size() != 0) begin
         void'(rxq.pop_front());
         pops++;
      end
      if (txf_push) txq.push_back(txf_data);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   logic [15:0] r_data;
   logic r_err, r_fwd;
   int r_waits;

   task automatic acc(input bit mem, input bit we, input logic [11:0] a,
                      input logic [15:0] wd);
      @(negedge clk);
      host_req = 1; host_mem = mem; host_we = we; host_addr = a; host_wdata = wd;
      r_waits = 0;
      #1;
      while (host_wait) begin
         r_waits++;
         @(negedge clk); #1;
      end
      r_data = host_rdata; r_err = host_err; r_fwd = reg_req;
      @(posedge clk); #1;
      host_req = 0;
   endtask

   task automatic t_reset();
      #1;
      check("R11 wait low", host_wait, 0);
      acc(0, 0, 12'h006, 0); check("R11 status", r_data, 0);
      acc(0, 0, 12'h002, 0); check("R11 rd count/window", r_data, 0);
      acc(0, 0, 12'h004, 0); check("R11 wr count", r_data, 0);
   endtask

   task automatic t_read_burst();
      int p0 = pops;
      for (int i = 0; i < 5; i++) rxq.push_back(16'hA000 + 16'(i));
      rx_en = 1;
      acc(0, 1, 12'h002, 16'd5);
      repeat (8) @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         acc(0, 0, 12'h000, 0);
         check("R3 read order", r_data, 16'hA000 + 16'(i));
      end
      check("R2 pops limited to count", pops - p0, 5);
      acc(0, 0, 12'h006, 0); check("R10 idle after burst", r_data, 0);
      acc(0, 0, 12'h000, 0);
      check("R5 empty read err", r_err, 1);
      check("R5 empty read data", r_data, 0);
   endtask

   task automatic t_prefetch();
      int p0 = pops;
      for (int i = 0; i < 20; i++) rxq.push_back(16'hB100 + 16'(i));
      acc(0, 1, 12'h002, 16'd20);
      repeat (20) @(negedge clk);
      check("R2 prefetch depth", pops - p0, 8);
      acc(0, 0, 12'h002, 0); check("R1 rd count after prefetch", r_data, 12);
      acc(0, 0, 12'h006, 0); check("R10 busy in burst", r_data, 1);
      for (int i = 0; i < 20; i++) begin
         acc(0, 0, 12'h000, 0);
         if (i == 0) check("R3 no wait when buffered", r_waits, 0);
         check("R3 prefetched data", r_data, 16'hB100 + 16'(i));
      end
   endtask

   task automatic t_read_wait();
      rx_en = 0;
      for (int i = 0; i < 3; i++) rxq.push_back(16'hC200 + 16'(i));
      acc(0, 1, 12'h002, 16'd3);
      fork
         acc(0, 0, 12'h000, 0);
         begin repeat (4) @(negedge clk); rx_en = 1; end
      join
      check("R3 wait while empty", r_waits >= 3, 1);
      check("R3 data after wait", r_data, 16'hC200);
      acc(0, 0, 12'h000, 0); check("R3 second word", r_data, 16'hC201);
      acc(0, 0, 12'h000, 0); check("R3 third word", r_data, 16'hC202);
   endtask

   task automatic t_write_burst();
      int w9;
      txq.delete();
      txf_ready = 0;
      acc(0, 1, 12'h004, 16'd12);
      w9 = 0;
      for (int i = 0; i < 8; i++) begin
         acc(0, 1, 12'h000, 16'hD300 + 16'(i));
         w9 += r_waits;
      end
      check("R4 no wait until full", w9, 0);
      acc(0, 0, 12'h004, 0); check("R1 wr count before drain", r_data, 12);
      fork
         acc(0, 1, 12'h000, 16'hD308);
         begin repeat (3) @(negedge clk); txf_ready = 1; end
      join
      check("R4 wait when full", r_waits >= 2, 1);
      for (int i = 9; i < 12; i++) acc(0, 1, 12'h000, 16'hD300 + 16'(i));
      repeat (12) @(negedge clk);
      check("R4 tx word count", txq.size(), 12);
      for (int i = 0; i < 12 && i < txq.size(); i++)
         check("R4 tx order", txq[i], 16'hD300 + 16'(i));
      acc(0, 0, 12'h006, 0); check("R10 idle after drain", r_data, 0);
      acc(0, 0, 12'h004, 0); check("R1 wr count drained", r_data, 0);
   endtask

   task automatic t_excess_write();
      txq.delete();
      acc(0, 1, 12'h004, 16'd2);
      acc(0, 1, 12'h000, 16'hE001); check("R5 write in count ok", r_err, 0);
      acc(0, 1, 12'h000, 16'hE002);
      acc(0, 1, 12'h000, 16'hE003); check("R5 excess write err", r_err, 1);
      repeat (4) @(negedge clk);
      check("R5 excess not delivered", txq.size(), 2);
   endtask

   task automatic t_gating();
      acc(0, 0, 12'h008, 0);
      check("R6 idle forward", r_fwd, 1);
      check("R6 idle forward data", r_data, 16'h5A5A);
      check("R6 idle no err", r_err, 0);
      rx_en = 0;
      acc(0, 1, 12'h002, 16'd4);
      acc(0, 1, 12'h00A, 16'h1234);
      check("R6 blocked no forward", r_fwd, 0);
      check("R6 blocked err", r_err, 1);
      acc(0, 1, 12'h004, 16'd0);
      acc(0, 0, 12'h006, 0); check("R7 zero write idles", r_data, 0);
      rx_en = 1;
   endtask

   task automatic t_cancel();
      int p1;
      rxq.delete();
      for (int i = 0; i < 10; i++) rxq.push_back(16'hF000 + 16'(i));
      acc(0, 1, 12'h002, 16'd10);
      repeat (12) @(negedge clk);
      acc(0, 1, 12'h002, 16'd0);
      p1 = pops;
      acc(0, 0, 12'h000, 0);
      check("R7 flushed read err", r_err, 1);
      check("R7 flushed read data", r_data, 0);
      repeat (5) @(negedge clk);
      check("R7 no fetch after cancel", pops - p1, 0);
      acc(0, 0, 12'h006, 0); check("R7 status after cancel", r_data, 0);
      rxq.delete();
   endtask

   task automatic t_window();
      int wins[5] = '{0, 3, 7, 18, 31};
      int kinds[5] = '{0, 1, 2, 3, 3};
      int idxs[5] = '{0, 0, 0, 13, 0};
      for (int i = 0; i < 5; i++) begin
         acc(0, 1, 12'h002, 16'(wins[i]) << 11);
         @(negedge clk);
         check("R8 window sel", win_sel, wins[i]);
         check("R8 window kind", win_kind, kinds[i]);
         check("R8 table index", win_tbl_idx, idxs[i]);
         acc(0, 0, 12'h002, 0);
         check("R1 window readback", r_data, 16'(wins[i]) << 11);
      end
      acc(0, 1, 12'h002, 0);
   endtask

   task automatic t_mem();
      int p0;
      rxq.delete();
      rxq.push_back(16'h9001); rxq.push_back(16'h9002);
      cfg_mem_route = 1;
      acc(1, 0, 12'h100, 0); check("R9 low mem is window", r_fwd, 1);
      acc(0, 1, 12'h002, 16'd2);
      repeat (4) @(negedge clk);
      acc(1, 0, 12'h900, 0); check("R9 routed mem read", r_data, 16'h9001);
      cfg_mem_route = 0;
      acc(1, 0, 12'h900, 0);
      check("R9 unrouted is window access", r_err, 1);
      check("R9 unrouted no data", r_data, 0);
      cfg_mem_route = 1;
      p0 = pops;
      acc(1, 0, 12'hA00, 0); check("R9 routed second word", r_data, 16'h9002);
      check("R9 no extra fetch", pops - p0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_read_burst();
      t_prefetch();
      t_read_wait();
      t_write_burst();
      t_excess_write();
      t_gating();
      t_cancel();
      t_window();
      t_mem();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule